// File: doc/BRIEF.md
# Dual-Map Interrupt Controller Register File

This block gathers up to 51 interrupt sources into one pending vector. It masks that vector with an enable mask and splits it into a normal-interrupt set and a fast-interrupt set, according to a per-source route bit. The results drive two processor interrupt lines, `irq` and `fiq`. Each source is captured according to three per-source settings:

- Sensitivity: level or edge.
- Polarity: active high / rising, or active low / falling.
- Both-edge option: an edge source can be set to pend on every transition.

Sensitivity and the both-edge option are fixed at build time through parameters. The polarity of the four highest-numbered sources can be changed by software.

Software reaches the same state through two register maps on one 8-bit-offset, 32-bit-data bus.

- Compact map, offsets 0x00 to 0x7F. It sees only sources 0 to 31.
- Wide map, offsets 0x80 and up. Every register there is 64 bits wide. Offset bit 2 picks the upper word, which carries sources 32 to 50.

Enable has separate set and clear registers. Pending bits of edge-sensitive sources are cleared by a write-one-to-clear register. Software-interrupt registers are decoded but always read zero.

The request side is a valid-only stream. There is no ready signal: a request presented with `req_valid` high is taken on that clock edge, every cycle, so the block never pushes back. Exactly one cycle later, `rsp_valid` pulses together with `rsp_data` and `rsp_err`. The response cannot be stalled, so the requester must take it in that cycle.

Top module: `dmic_top`

## Requirements
- R1: An offset below 0x80 addresses the compact map and always refers to bits 31:0. At 0x80 and above, offset bit 2 selects the upper word (bits 50:32, returned in data bits 18:0 with bits 31:19 zero), and the register is decoded with bit 2 cleared.
- R2: A request with `req_valid` high gets `rsp_valid` high on the next cycle. Nothing else raises `rsp_valid`. `rsp_data` holds the register value as it was before any write taken at that same edge, and holds zero for writes and unmapped offsets.
- R3: The status registers read as follows, with `route` bit 1 meaning fast interrupt:

  | Offset (compact / wide) | Value |
  |---|---|
  | 0x00 / 0x80 | pending & ~route & enable |
  | 0x04 / 0x88 | pending & route & enable |
  | 0x08 / 0x90 | pending |
  | none / 0xE0 | pending & ~sensitivity |

- R4: `irq` is the OR of all bits of pending & ~route & enable, and `fiq` is the OR of all bits of pending & route & enable, with no register stage.
- R5: Writing enable (0x10 / 0xA0) ORs the data into the enable mask. Writing enable-clear (0x14 / 0xA8) clears the bits written as 1.
- R6: Writing route (0x0C / 0x98) replaces only the addressed 32-bit half. The other half keeps its value.
- R7: Writing edge-clear (0x38 / 0xD8) clears a pending bit only where the data bit is 1 and the source is edge-sensitive (sensitivity bit 0). Level-sensitive pending bits are unaffected.
- R8: A polarity write (0x2C / 0xD0) is taken only if it alters nothing but the polarity bits of the four highest sources. Any other write there leaves polarity unchanged.
- R9: `rsp_err` pulses with `rsp_valid` for two cases: a write to any status, pending, sensitivity or both-edge register, and a read of the enable-clear, software-clear (0x1C / 0xB8) or edge-clear register. The register state is unchanged in both cases.
- R10: A level source (sensitivity 1) makes its pending bit equal to (input == polarity) one cycle later. An edge source sets its pending bit on the rising edge (polarity 1), the falling edge (polarity 0), or either edge when its both-edge bit is 1.
- R11: Reset clears pending, route, enable and the response outputs, and loads the build-time values of sensitivity, both-edge and polarity. The default builds are:

  | Setting | Default build |
  |---|---|
  | Level-sensitive sources | 16 to 31 |
  | Both-edge sources | source 2 only |
  | Polarity | 1 everywhere except sources 1 and 17 |

- R12: The software-interrupt registers (0x18 / 0xB0) read zero, and writes to them neither change state nor raise `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present; always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_data | output | 32 | Read data |
| rsp_err | output | 1 | Illegal-access flag, valid with rsp_valid |
| src_in | input | NSRC | Interrupt source inputs |
| irq | output | 1 | Normal interrupt line |
| fiq | output | 1 | Fast interrupt line |

## Verification
The hardest situation to reach is a pending vector holding level, single-edge and both-edge sources at once, with an edge-clear write aimed at all of them. Only that combination shows whether the clear spares level-sensitive bits. The stimulus therefore moves source inputs one at a time, toggling an active-low level source, a falling-edge source and the both-edge source, and reads the pending register between steps. It then issues one clear whose mask covers both kinds. Polarity of a top source is changed only through an upper-word wide-map write. Its new edge sense is then shown by a rising transition that must not pend, followed by a falling one that must.

// File: rtl/dmic_pkg.sv
package dmic_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_IRQ_ST, K_FIQ_ST, K_PEND, K_ROUTE, K_EN_SET, K_EN_CLR,
    K_SW_SET, K_SW_CLR, K_SENSE, K_BOTH, K_POL, K_EDGE_CLR, K_EDGE_ST
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e kind;
    logic      upper;
  } reg_sel_t;

  localparam logic [7:0] WIDE_BASE = 8'h80;

  function automatic reg_sel_t decode(input logic [7:0] a);
    reg_sel_t r;
    logic [7:0] key;
    r.kind  = K_NONE;
    r.upper = 1'b0;
    if (a < WIDE_BASE) begin
      unique case (a)
        8'h00:   r.kind = K_IRQ_ST;
        8'h04:   r.kind = K_FIQ_ST;
        8'h08:   r.kind = K_PEND;
        8'h0C:   r.kind = K_ROUTE;
        8'h10:   r.kind = K_EN_SET;
        8'h14:   r.kind = K_EN_CLR;
        8'h18:   r.kind = K_SW_SET;
        8'h1C:   r.kind = K_SW_CLR;
        8'h24:   r.kind = K_SENSE;
        8'h28:   r.kind = K_BOTH;
        8'h2C:   r.kind = K_POL;
        8'h38:   r.kind = K_EDGE_CLR;
        default: r.kind = K_NONE;
      endcase
    end else begin
      r.upper = a[2];
      key     = a & 8'hFB;
      unique case (key)
        8'h80:   r.kind = K_IRQ_ST;
        8'h88:   r.kind = K_FIQ_ST;
        8'h90:   r.kind = K_PEND;
        8'h98:   r.kind = K_ROUTE;
        8'hA0:   r.kind = K_EN_SET;
        8'hA8:   r.kind = K_EN_CLR;
        8'hB0:   r.kind = K_SW_SET;
        8'hB8:   r.kind = K_SW_CLR;
        8'hC0:   r.kind = K_SENSE;
        8'hC8:   r.kind = K_BOTH;
        8'hD0:   r.kind = K_POL;
        8'hD8:   r.kind = K_EDGE_CLR;
        8'hE0:   r.kind = K_EDGE_ST;
        default: r.kind = K_NONE;
      endcase
    end
    return r;
  endfunction

  // Places a 32-bit bus word into the addressed half of a 64-bit register.
  function automatic logic [63:0] place_word(input logic [31:0] w, input logic upper);
    return upper ? {w, 32'h0} : {32'h0, w};
  endfunction

endpackage

// File: rtl/dmic_capture.sv
module dmic_capture #(
  parameter int unsigned NSRC = 51
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] sense,
  input  logic [NSRC-1:0] both,
  input  logic [NSRC-1:0] pol,
  input  logic [NSRC-1:0] clr_req,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] src_q, rise, fall, hit, lvl, pend_n;

  assign rise   = src_in & ~src_q;
  assign fall   = ~src_in & src_q;
  assign hit    = (rise & (pol | both)) | (fall & (~pol | both));
  assign lvl    = ~(src_in ^ pol);
  // A fresh edge wins over a clear taken at the same edge.
  assign pend_n = (sense & lvl) | (~sense & ((pend & ~clr_req) | hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      pend  <= '0;
    end else begin
      src_q <= src_in;
      pend  <= pend_n;
    end
  end
endmodule

// File: rtl/dmic_cfg.sv
module dmic_cfg
  import dmic_pkg::*;
#(
  parameter int unsigned     NSRC      = 51,
  parameter int unsigned     TOP_EVT   = 4,
  parameter logic [NSRC-1:0] EVENT_RST = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  reg_kind_e       kind,
  input  logic            upper,
  input  logic [31:0]     wdata,
  output logic [NSRC-1:0] route,
  output logic [NSRC-1:0] enable,
  output logic [NSRC-1:0] pol
);
  localparam logic [NSRC-1:0] POL_FIXED = {{TOP_EVT{1'b0}}, {(NSRC-TOP_EVT){1'b1}}};

  logic [NSRC-1:0] dvec, mvec, pol_n;
  logic            pol_ok;

  assign dvec   = NSRC'(place_word(wdata, upper));
  assign mvec   = NSRC'(place_word(32'hFFFF_FFFF, upper));
  assign pol_n  = (pol & ~mvec) | dvec;
  assign pol_ok = ((pol_n ^ pol) & POL_FIXED) == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route  <= '0;
      enable <= '0;
      pol    <= EVENT_RST;
    end else if (wr_en) begin
      unique case (kind)
        K_ROUTE:  route  <= (route & ~mvec) | dvec;
        K_EN_SET: enable <= enable | dvec;
        K_EN_CLR: enable <= enable & ~dvec;
        K_POL:    if (pol_ok) pol <= pol_n;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/dmic_readback.sv
module dmic_readback
  import dmic_pkg::*;
#(
  parameter int unsigned NSRC = 51
) (
  input  reg_kind_e       kind,
  input  logic            upper,
  input  logic            is_write,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] route,
  input  logic [NSRC-1:0] enable,
  input  logic [NSRC-1:0] sense,
  input  logic [NSRC-1:0] both,
  input  logic [NSRC-1:0] pol,
  output logic [31:0]     word,
  output logic            illegal
);
  logic [NSRC-1:0] val;

  always_comb begin
    unique case (kind)
      K_IRQ_ST:  val = pend & ~route & enable;
      K_FIQ_ST:  val = pend & route & enable;
      K_PEND:    val = pend;
      K_ROUTE:   val = route;
      K_EN_SET:  val = enable;
      K_SENSE:   val = sense;
      K_BOTH:    val = both;
      K_POL:     val = pol;
      K_EDGE_ST: val = pend & ~sense;
      default:   val = '0;
    endcase
  end

  assign word = upper ? 32'(val >> 32) : val[31:0];

  always_comb begin
    if (is_write)
      illegal = kind inside {K_IRQ_ST, K_FIQ_ST, K_PEND, K_SENSE, K_BOTH, K_EDGE_ST};
    else
      illegal = kind inside {K_EN_CLR, K_SW_CLR, K_EDGE_CLR};
  end
endmodule

// File: rtl/dmic_top.sv
module dmic_top
  import dmic_pkg::*;
#(
  parameter int unsigned     NSRC      = 51,
  parameter int unsigned     TOP_EVT   = 4,
  parameter logic [NSRC-1:0] LEVEL_SRC = NSRC'(64'hFFFF_0000),
  parameter logic [NSRC-1:0] BOTH_SRC  = NSRC'(64'h4),
  parameter logic [NSRC-1:0] EVENT_RST = ~NSRC'(64'h2_0002)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [7:0]      req_addr,
  input  logic [31:0]     req_wdata,
  output logic            rsp_valid,
  output logic [31:0]     rsp_data,
  output logic            rsp_err,
  input  logic [NSRC-1:0] src_in,
  output logic            irq,
  output logic            fiq
);
  reg_sel_t        dec;
  logic            wr_en;
  logic [NSRC-1:0] pend_q, route_q, enable_q, pol_q, edge_clr;
  logic [31:0]     rd_word;
  logic            rd_illegal;

  assign dec      = decode(req_addr);
  assign wr_en    = req_valid && req_write;
  assign edge_clr = (wr_en && dec.kind == K_EDGE_CLR)
                    ? NSRC'(place_word(req_wdata, dec.upper)) : '0;

  dmic_capture #(.NSRC(NSRC)) u_cap (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .sense(LEVEL_SRC),
    .both(BOTH_SRC), .pol(pol_q), .clr_req(edge_clr), .pend(pend_q)
  );

  dmic_cfg #(.NSRC(NSRC), .TOP_EVT(TOP_EVT), .EVENT_RST(EVENT_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .kind(dec.kind),
    .upper(dec.upper), .wdata(req_wdata), .route(route_q),
    .enable(enable_q), .pol(pol_q)
  );

  dmic_readback #(.NSRC(NSRC)) u_rb (
    .kind(dec.kind), .upper(dec.upper), .is_write(req_write),
    .pend(pend_q), .route(route_q), .enable(enable_q), .sense(LEVEL_SRC),
    .both(BOTH_SRC), .pol(pol_q), .word(rd_word), .illegal(rd_illegal)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_data  <= (req_valid && !req_write) ? rd_word : '0;
      rsp_err   <= req_valid && rd_illegal;
    end
  end

  assign irq = |(pend_q & ~route_q & enable_q);
  assign fiq = |(pend_q & route_q & enable_q);
endmodule

// File: rtl/dmic_chk.sv
module dmic_chk #(
  parameter int unsigned NSRC    = 51,
  parameter int unsigned TOP_EVT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [7:0]      req_addr,
  input logic [31:0]     req_wdata,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic            irq,
  input logic            fiq,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] route,
  input logic [NSRC-1:0] enable,
  input logic [NSRC-1:0] pol
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_IRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(pend & ~route & enable)); // R4
  AST_FIQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    fiq == |(pend & route & enable)); // R4
  AST_EN_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 8'h10)
      |=> ((enable[31:0] & $past(req_wdata)) == $past(req_wdata))); // R5
  AST_EN_CLR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 8'h14)
      |=> ((enable[31:0] & $past(req_wdata)) == 32'h0)); // R5
  AST_ROUTE_HALF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 8'h98)
      |=> (route[NSRC-1:32] == $past(route[NSRC-1:32]))); // R6
  AST_POL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pol[NSRC-TOP_EVT-1:0])); // R8
  AST_RO_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 8'h00) |=> rsp_err); // R9
  AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R9
endmodule

bind dmic_top dmic_chk #(.NSRC(NSRC), .TOP_EVT(TOP_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .irq(irq), .fiq(fiq), .pend(pend_q), .route(route_q),
  .enable(enable_q), .pol(pol_q)
);

// File: tb/tb_dmic_top.sv
module tb_dmic_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 51;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_write = 1'b0;
  logic [7:0]      req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid, rsp_err, irq, fiq;
  logic [31:0]     rsp_data;
  logic [NSRC-1:0] src_in = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] d;
    logic        e;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmic_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .src_in(src_in),
    .irq(irq), .fiq(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every response strobe.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected response", 32'h1, 32'h0);
      end else begin
        mon_e = exp_q.pop_front();
        chk({mon_e.tag, " data"}, rsp_data, mon_e.d);
        chk({mon_e.tag, " err"}, {31'h0, rsp_err}, {31'h0, mon_e.e});
      end
    end
  end

  // Driver: called at a falling edge, returns at the next falling edge.
  task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [31:0] exp, input logic exp_err, input string tag);
    exp_t e;
    e.d = wr ? 32'h0 : exp;
    e.e = exp_err;
    e.tag = tag;
    exp_q.push_back(e);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus(1'b0, a, 32'h0, exp, 1'b0, tag);
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    bus(1'b1, a, d, 32'h0, 1'b0, tag);
  endtask
  task automatic set_src(input int idx, input logic v);
    src_in[idx] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R11 reset rsp_err", {31'h0, rsp_err}, 32'h0);
    chk("R11 reset irq", {31'h0, irq}, 32'h0);
    chk("R11 reset fiq", {31'h0, fiq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    // Build-time configuration and active-low level source 17
    rd(8'h08, 32'h0002_0000, "R10 active-low level pends");
    rd(8'h24, 32'hFFFF_0000, "R11 sensitivity");
    rd(8'hC8, 32'h0000_0004, "R11 both-edge low");
    rd(8'hCC, 32'h0000_0000, "R11 both-edge high");
    rd(8'h2C, 32'hFFFD_FFFD, "R11 polarity low");
    rd(8'hD4, 32'h0007_FFFF, "R1 polarity high 19 bits");

    // Enable set/clear across both maps
    wr(8'h10, 32'h0000_0003, "R5 enable set");
    wr(8'hA4, 32'h0001_0001, "R5 enable set high");
    rd(8'h10, 32'h0000_0003, "R5 enable low");
    rd(8'hA4, 32'h0001_0001, "R1 enable high word");
    wr(8'h14, 32'h0000_0001, "R5 enable clear");
    rd(8'hA0, 32'h0000_0002, "R5 enable after clear");
    chk("R4 irq masked", {31'h0, irq}, 32'h0);
    wr(8'h10, 32'h0002_0000, "R5 enable bit17");
    chk("R4 irq on", {31'h0, irq}, 32'h1);
    chk("R4 fiq off", {31'h0, fiq}, 32'h0);
    rd(8'h00, 32'h0002_0000, "R3 irq status");
    rd(8'h04, 32'h0000_0000, "R3 fiq status");

    // Route halves
    wr(8'h98, 32'h0002_0000, "R6 route low");
    chk("R4 fiq on", {31'h0, fiq}, 32'h1);
    chk("R4 irq off", {31'h0, irq}, 32'h0);
    rd(8'h88, 32'h0002_0000, "R3 fiq status wide");
    rd(8'h80, 32'h0000_0000, "R3 irq status wide");
    wr(8'h9C, 32'h0000_0005, "R6 route high");
    rd(8'h98, 32'h0002_0000, "R6 low half kept");
    rd(8'h0C, 32'h0002_0000, "R1 compact route alias");
    wr(8'h0C, 32'h0000_0000, "R6 compact route low");
    rd(8'h9C, 32'h0000_0005, "R6 high half kept");
    chk("R4 irq back", {31'h0, irq}, 32'h1);

    // Level source goes inactive
    set_src(17, 1'b1);
    chk("R10 level follows input", {31'h0, irq}, 32'h0);

    // Edge sources
    set_src(0, 1'b1);
    set_src(1, 1'b1);
    rd(8'h08, 32'h0000_0001, "R10 rising edge / no fall yet");
    set_src(1, 1'b0);
    chk("R10 falling edge irq", {31'h0, irq}, 32'h1);
    rd(8'h08, 32'h0000_0003, "R10 falling edge pends");
    rd(8'hE0, 32'h0000_0003, "R3 edge status");
    set_src(2, 1'b1);
    rd(8'h08, 32'h0000_0007, "R10 both-edge rise");
    wr(8'h38, 32'h0000_0004, "R7 edge clear");
    rd(8'h08, 32'h0000_0003, "R7 edge bit cleared");
    set_src(2, 1'b0);
    rd(8'h08, 32'h0000_0007, "R10 both-edge fall");
    set_src(17, 1'b0);
    wr(8'hD8, 32'h0002_0001, "R7 clear mixed");
    rd(8'h08, 32'h0002_0006, "R7 level bit kept");

    // Illegal accesses
    bus(1'b1, 8'h90, 32'hFFFF_FFFF, 32'h0, 1'b1, "R9 write pending");
    rd(8'h08, 32'h0002_0006, "R9 pending unchanged");
    bus(1'b1, 8'h24, 32'h0, 32'h0, 1'b1, "R9 write sensitivity");
    rd(8'h24, 32'hFFFF_0000, "R9 sensitivity unchanged");
    bus(1'b0, 8'h14, 32'h0, 32'h0, 1'b1, "R9 read enable clear");
    bus(1'b0, 8'hD8, 32'h0, 32'h0, 1'b1, "R9 read edge clear");
    bus(1'b0, 8'h1C, 32'h0, 32'h0, 1'b1, "R9 read software clear");

    // Software interrupt registers
    wr(8'h18, 32'h0000_0001, "R12 software write no error");
    rd(8'hB0, 32'h0000_0000, "R12 software reads zero");
    rd(8'h08, 32'h0002_0006, "R12 pending untouched");

    // Polarity of the top sources
    wr(8'h2C, 32'h0000_0000, "R8 locked write");
    rd(8'h2C, 32'hFFFD_FFFD, "R8 low polarity kept");
    wr(8'hD4, 32'h0007_FFFE, "R8 write touching source 32");
    rd(8'hD4, 32'h0007_FFFF, "R8 high polarity kept");
    wr(8'hD4, 32'h0006_FFFF, "R8 source 48 to falling");
    rd(8'hD4, 32'h0006_FFFF, "R8 top polarity changed");
    set_src(48, 1'b1);
    rd(8'h94, 32'h0000_0000, "R8 rise ignored after change");
    set_src(48, 1'b0);
    rd(8'h94, 32'h0001_0000, "R1 pending high word");
    rd(8'h84, 32'h0001_0000, "R3 irq status high");
    rd(8'h8C, 32'h0000_0000, "R3 fiq status high");

    repeat (3) @(negedge clk);
    chk("R2 all responses seen", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule